// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

This block is a general-purpose serial shifter for SPI-style three-wire links with no slave select. It has a data-in pin, a data-out pin and a serial clock. One byte-wide shift register and a small edge counter advance together from a clock source chosen at run time. That source is the external clock pin, a one-cycle timer compare-match pulse, or a one-cycle software strobe. The data-out pin always shows the most significant bit of the shift register.

A parallel bus loads and reads both the shift register and the counter. The counter counts clock edges, not bits. A full byte therefore takes two steps per bit, and the counter wraps exactly once. The wrap sets a sticky overflow flag that software uses as the end-of-transfer interrupt.

As a master, software or the timer makes the clock. Every accepted timer or software pulse toggles the clock output and also advances the counter by one, so the pin and the counter stay in step. The external pin and data input are synchronized into the system clock before use.

Top module: `serial_shifter3w`

## Requirements
- R1: After reset the shift register, counter, overflow flag, clock output and data output are all 0, and shiftOut and cntOut show the register values.
- R2: srcSel selects the step source: 2'b01 the synchronized clock pin, 2'b10 timerMatch, 2'b11 swToggle, 2'b00 none. Activity on a source that is not selected changes neither the counter, the shift register nor sckOut.
- R3: With the pin source, every rising and every falling edge of sckIn advances the counter by one. The new count is visible three system clock edges after the pin changes (two synchronizer stages plus the edge register).
- R4: With the timer or software source, each one-cycle pulse advances the counter by one and toggles sckOut on the next clock edge. A pulse taken while sckOut is 0 counts as a rising edge, and one taken while sckOut is 1 counts as a falling edge.
- R5: With sampleFall=0, rising edges capture the synchronized DI into a sample stage and falling edges shift the register left, inserting that stage at bit 0. With sampleFall=1 the two edge roles swap. doOut equals bit 7 of the shift register.
- R6: A step taken at count 15 wraps the counter to 0 and sets ovfFlag. In mode 0, sixteen steps starting with the clock low move a whole byte: the register ends holding the DI bits, presented MSB first.
- R7: ovfFlag stays set until ovfClr is pulsed high. If a wrap coincides with the clear, the flag ends set.
- R8: A counter write (cntWr) wins over a simultaneous step, and a shift register write (shWr) wins over a simultaneous shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock pin input (asynchronous) |
| diIn | input | 1 | Serial data input pin (asynchronous) |
| srcSel | input | 2 | Step source select |
| sampleFall | input | 1 | 0: sample on rising and shift on falling; 1: the reverse |
| swToggle | input | 1 | Software clock strobe, one cycle per step |
| timerMatch | input | 1 | Timer compare-match pulse |
| shWr | input | 1 | Parallel write of the shift register |
| shWrData | input | DATA_W | Shift register write data |
| cntWr | input | 1 | Parallel write of the counter |
| cntWrData | input | CNT_W | Counter write data |
| ovfClr | input | 1 | Clears the overflow flag when high |
| sckOut | output | 1 | Generated serial clock for master use |
| doOut | output | 1 | Serial data output |
| shiftOut | output | DATA_W | Shift register read value |
| cntOut | output | CNT_W | Counter read value |
| ovfFlag | output | 1 | Sticky counter overflow flag |

## Verification
The bench builds the block with DATA_W=8 and SYNC_STAGES=2, which gives a 4-bit counter. A whole byte exchange therefore fits in sixteen steps, and the wrap from 15 to 0 can be reached in every table vector. The two-stage synchronizer makes the three-edge pin latency exact, so it is checked cycle by cycle. Both edge modes are run against all three clock sources, so the stale sample stage shifted in first in mode 1 shows up in the expected data.

// File: rtl/sshift_pkg.sv
package sshift_pkg;

  // Clock source selection; encoding is fixed by requirement R2
  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_PIN   = 2'b01,
    SRC_TIMER = 2'b10,
    SRC_SOFT  = 2'b11
  } clkSrcE;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleNow;
    logic shiftNow;
    logic diBit;
  } shStrobeT;

endpackage

// File: rtl/sshift_ctrl.sv
module sshift_ctrl
  import sshift_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckIn,
  input  logic             diIn,
  input  logic [1:0]       srcSel,
  input  logic             sampleFall,
  input  logic             swToggle,
  input  logic             timerMatch,
  input  logic             cntWr,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             ovfClr,
  output logic             sckOut,
  output logic [CNT_W-1:0] cntOut,
  output logic             ovfFlag,
  output shStrobeT         strobes
);

  logic [SYNC_STAGES-1:0] sckChain;
  logic [SYNC_STAGES-1:0] diChain;
  logic                   sckPrev;
  logic                   sckSync;
  logic                   pinRise;
  logic                   pinFall;
  logic                   step;
  logic                   rising;
  logic                   genMode;
  logic [CNT_W-1:0]       cnt;
  logic                   sckReg;
  logic                   ovfReg;
  clkSrcE                 src;

  assign src = clkSrcE'(srcSel);

  // Input synchronizers for the pin clock and data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckChain <= '0;
      diChain  <= '0;
      sckPrev  <= 1'b0;
    end else begin
      sckChain <= {sckChain[SYNC_STAGES-2:0], sckIn};
      diChain  <= {diChain[SYNC_STAGES-2:0], diIn};
      sckPrev  <= sckChain[SYNC_STAGES-1];
    end
  end

  assign sckSync = sckChain[SYNC_STAGES-1];
  assign pinRise = sckSync & ~sckPrev;
  assign pinFall = ~sckSync & sckPrev;

  // Step source multiplexer
  always_comb begin
    step    = 1'b0;
    rising  = 1'b0;
    genMode = 1'b0;
    unique case (src)
      SRC_PIN: begin
        step   = pinRise | pinFall;
        rising = pinRise;
      end
      SRC_TIMER: begin
        step    = timerMatch;
        rising  = ~sckReg;
        genMode = 1'b1;
      end
      SRC_SOFT: begin
        step    = swToggle;
        rising  = ~sckReg;
        genMode = 1'b1;
      end
      default: ;
    endcase
  end

  // Generated clock, edge counter and overflow flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckReg <= 1'b0;
      cnt    <= '0;
      ovfReg <= 1'b0;
    end else begin
      if (step && genMode) sckReg <= ~sckReg;
      if (cntWr)      cnt <= cntWrData;
      else if (step)  cnt <= cnt + 1'b1;
      if (step && !cntWr && (cnt == '1)) ovfReg <= 1'b1;
      else if (ovfClr)                   ovfReg <= 1'b0;
    end
  end

  assign strobes.sampleNow = step & (rising ^ sampleFall);
  assign strobes.shiftNow  = step & ~(rising ^ sampleFall);
  assign strobes.diBit     = diChain[SYNC_STAGES-1];

  assign sckOut  = sckReg;
  assign cntOut  = cnt;
  assign ovfFlag = ovfReg;

endmodule

// File: rtl/sshift_dp.sv
module sshift_dp
  import sshift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shStrobeT          strobes,
  input  logic              shWr,
  input  logic [DATA_W-1:0] shWrData,
  output logic [DATA_W-1:0] shiftOut,
  output logic              doOut
);

  logic [DATA_W-1:0] shReg;
  logic              sampleBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      sampleBit <= 1'b0;
    end else begin
      if (strobes.sampleNow) sampleBit <= strobes.diBit;
      if (shWr)                  shReg <= shWrData;
      else if (strobes.shiftNow) shReg <= {shReg[DATA_W-2:0], sampleBit};
    end
  end

  assign shiftOut = shReg;
  assign doOut    = shReg[DATA_W-1];

endmodule

// File: rtl/serial_shifter3w.sv
module serial_shifter3w
  import sshift_pkg::*;
#(
  parameter  int DATA_W      = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              diIn,
  input  logic [1:0]        srcSel,
  input  logic              sampleFall,
  input  logic              swToggle,
  input  logic              timerMatch,
  input  logic              shWr,
  input  logic [DATA_W-1:0] shWrData,
  input  logic              cntWr,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic              ovfClr,
  output logic              sckOut,
  output logic              doOut,
  output logic [DATA_W-1:0] shiftOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic              ovfFlag
);

  shStrobeT strobes;

  sshift_ctrl #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .diIn(diIn), .srcSel(srcSel),
    .sampleFall(sampleFall), .swToggle(swToggle), .timerMatch(timerMatch),
    .cntWr(cntWr), .cntWrData(cntWrData), .ovfClr(ovfClr),
    .sckOut(sckOut), .cntOut(cntOut), .ovfFlag(ovfFlag), .strobes(strobes)
  );

  sshift_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .shWr(shWr),
    .shWrData(shWrData), .shiftOut(shiftOut), .doOut(doOut)
  );

endmodule

// File: rtl/sshift_chk.sv
module sshift_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        srcSel,
  input logic              swToggle,
  input logic              timerMatch,
  input logic              shWr,
  input logic [DATA_W-1:0] shWrData,
  input logic              cntWr,
  input logic [CNT_W-1:0]  cntWrData,
  input logic              ovfClr,
  input logic              sckOut,
  input logic [DATA_W-1:0] shiftOut,
  input logic [CNT_W-1:0]  cntOut,
  input logic              ovfFlag
);

  // R4
  soft_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b11 && swToggle) |=> (sckOut != $past(sckOut)));

  // R2
  idle_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b00 && !cntWr) |=> (cntOut == $past(cntOut)));

  // R2
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b00) |=> $stable(sckOut));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntOut == '1 && !cntWr && ((srcSel == 2'b11 && swToggle) ||
                                (srcSel == 2'b10 && timerMatch))) |=> ovfFlag);

  // R8
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (cntOut == $past(cntWrData)));

  // R8
  sh_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    shWr |=> (shiftOut == $past(shWrData)));

endmodule

bind serial_shifter3w sshift_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .srcSel(srcSel), .swToggle(swToggle),
  .timerMatch(timerMatch), .shWr(shWr), .shWrData(shWrData), .cntWr(cntWr),
  .cntWrData(cntWrData), .ovfClr(ovfClr), .sckOut(sckOut),
  .shiftOut(shiftOut), .cntOut(cntOut), .ovfFlag(ovfFlag)
);

// File: tb/test_serial_shifter3w.sv
module test_serial_shifter3w;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sckIn = 1'b0, diIn = 1'b0;
  logic [1:0] srcSel = 2'b00;
  logic       sampleFall = 1'b0, swToggle = 1'b0, timerMatch = 1'b0;
  logic       shWr = 1'b0, cntWr = 1'b0, ovfClr = 1'b0;
  logic [7:0] shWrData = '0;
  logic [3:0] cntWrData = '0;
  logic       sckOut, doOut, ovfFlag;
  logic [7:0] shiftOut;
  logic [3:0] cntOut;

  int checks = 0;
  int errors = 0;

  // Bench model state
  logic [7:0] mShift = '0;
  logic       mSample = 1'b0;
  logic [3:0] mCnt = '0;
  logic       pinLvl = 1'b0;
  logic       sckLvl = 1'b0;

  always #2.5 clk = ~clk;

  serial_shifter3w i_serial_shifter3w (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .diIn(diIn), .srcSel(srcSel),
    .sampleFall(sampleFall), .swToggle(swToggle), .timerMatch(timerMatch),
    .shWr(shWr), .shWrData(shWrData), .cntWr(cntWr), .cntWrData(cntWrData),
    .ovfClr(ovfClr), .sckOut(sckOut), .doOut(doOut), .shiftOut(shiftOut),
    .cntOut(cntOut), .ovfFlag(ovfFlag)
  );

  // Vectors: {sampleFall, srcSel[1:0], loadByte[7:0], diByte[7:0]}
  localparam logic [18:0] VECS [6] = '{
    {1'b0, 2'b01, 8'hA5, 8'h3C},
    {1'b0, 2'b11, 8'h0F, 8'hF0},
    {1'b0, 2'b10, 8'h81, 8'h7E},
    {1'b1, 2'b11, 8'hC3, 8'h55},
    {1'b1, 2'b01, 8'h5A, 8'h99},
    {1'b0, 2'b11, 8'hFF, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock step from the current source; updates the model
  task automatic doStep(input logic di);
    logic rising;
    diIn = di;
    repeat (3) @(negedge clk);
    if (srcSel == 2'b01) begin
      rising = ~pinLvl;
      pinLvl = ~pinLvl;
      sckIn  = pinLvl;
      repeat (3) @(negedge clk);
    end else begin
      rising = ~sckLvl;
      sckLvl = ~sckLvl;
      if (srcSel == 2'b11) swToggle = 1'b1; else timerMatch = 1'b1;
      @(negedge clk);
      swToggle = 1'b0;
      timerMatch = 1'b0;
    end
    if (rising ^ sampleFall) mSample = di;
    else mShift = {mShift[6:0], mSample};
    mCnt = mCnt + 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(shiftOut == 8'h00, "R1 shift", shiftOut, 0);
    chk(cntOut == 4'h0, "R1 count", cntOut, 0);
    chk(ovfFlag == 1'b0 && sckOut == 1'b0 && doOut == 1'b0, "R1 flags",
        {ovfFlag, sckOut, doOut}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R5, R6, R3, R4
    foreach (VECS[v]) begin
      sampleFall = VECS[v][18];
      srcSel     = VECS[v][17:16];
      shWr = 1'b1; shWrData = VECS[v][15:8];
      cntWr = 1'b1; cntWrData = 4'h0; ovfClr = 1'b1;
      @(negedge clk);
      shWr = 1'b0; cntWr = 1'b0; ovfClr = 1'b0;
      mShift = VECS[v][15:8];
      mCnt = 4'h0;
      for (int s = 0; s < 16; s++) begin
        doStep(VECS[v][7 - s / 2]);
        chk(shiftOut == mShift, "R5 shift data", shiftOut, mShift);
        chk(doOut == mShift[7], "R5 data out", doOut, mShift[7]);
        chk(cntOut == mCnt, "R3 R4 count", cntOut, mCnt);
        if (s == 14) chk(ovfFlag == 1'b0, "R6 no early overflow", ovfFlag, 0);
      end
      chk(ovfFlag == 1'b1, "R6 overflow after byte", ovfFlag, 1);
      if (!VECS[v][18])
        chk(shiftOut == VECS[v][7:0], "R6 byte received", shiftOut, VECS[v][7:0]);
    end

    // R3 pin latency
    srcSel = 2'b01; sampleFall = 1'b0;
    cntWr = 1'b1; cntWrData = 4'h0; ovfClr = 1'b1;
    @(negedge clk);
    cntWr = 1'b0; ovfClr = 1'b0;
    pinLvl = ~pinLvl; sckIn = pinLvl;
    repeat (2) @(negedge clk);
    chk(cntOut == 4'h0, "R3 not before third edge", cntOut, 0);
    @(negedge clk);
    chk(cntOut == 4'h1, "R3 count on third edge", cntOut, 1);

    // R2 unselected sources ignored
    srcSel = 2'b00;
    swToggle = 1'b1; timerMatch = 1'b1;
    pinLvl = ~pinLvl; sckIn = pinLvl;
    @(negedge clk);
    swToggle = 1'b0; timerMatch = 1'b0;
    repeat (4) @(negedge clk);
    chk(cntOut == 4'h1, "R2 off source count", cntOut, 1);
    chk(sckOut == sckLvl, "R2 off source clock", sckOut, sckLvl);
    srcSel = 2'b11;
    timerMatch = 1'b1;
    @(negedge clk);
    timerMatch = 1'b0;
    @(negedge clk);
    chk(cntOut == 4'h1, "R2 timer ignored in soft mode", cntOut, 1);
    chk(sckOut == sckLvl, "R2 timer ignored clock", sckOut, sckLvl);

    // R4 timer toggles clock next edge
    srcSel = 2'b10;
    timerMatch = 1'b1;
    @(negedge clk);
    timerMatch = 1'b0;
    sckLvl = ~sckLvl;
    chk(sckOut == sckLvl, "R4 timer toggle", sckOut, sckLvl);
    chk(cntOut == 4'h2, "R4 timer count", cntOut, 2);

    // R7 clear, then wrap coinciding with clear
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    chk(ovfFlag == 1'b0, "R7 clear", ovfFlag, 0);
    srcSel = 2'b11;
    cntWr = 1'b1; cntWrData = 4'hF;
    @(negedge clk);
    cntWr = 1'b0;
    swToggle = 1'b1; ovfClr = 1'b1;
    @(negedge clk);
    swToggle = 1'b0; ovfClr = 1'b0;
    sckLvl = ~sckLvl;
    chk(ovfFlag == 1'b1, "R7 set wins over clear", ovfFlag, 1);
    chk(cntOut == 4'h0, "R6 wrap to zero", cntOut, 0);
    @(negedge clk);
    chk(ovfFlag == 1'b1, "R7 sticky", ovfFlag, 1);

    // R8 write priority; make next soft step a falling (shift) edge in mode 0
    sampleFall = 1'b0;
    if (sckLvl == 1'b0) begin
      swToggle = 1'b1;
      @(negedge clk);
      swToggle = 1'b0;
      sckLvl = 1'b1;
    end
    swToggle = 1'b1; shWr = 1'b1; shWrData = 8'h3C;
    cntWr = 1'b1; cntWrData = 4'h9;
    @(negedge clk);
    swToggle = 1'b0; shWr = 1'b0; cntWr = 1'b0;
    chk(shiftOut == 8'h3C, "R8 shift write wins", shiftOut, 8'h3C);
    chk(cntOut == 4'h9, "R8 count write wins", cntOut, 9);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule